// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block turns one high-level bus transaction request into the ordered list of byte-level primitives that an underlying two-wire bus engine carries out. The host chooses a transaction kind, a 7-bit target address, a command byte, up to two bytes of immediate write data, a length and option flags, and then pulses start. The sequencer asks the engine for a start with address, byte sends, byte receives (acknowledged or not acknowledged) and a stop, one at a time. Each request is held until the engine accepts it.

Block transfers use a small internal byte store. The host fills it before a block write and reads it by index after a block read. When the transaction finishes, the block pulses done and reports an error flag, up to 16 bits of read data and the number of data bytes it received. Bit timing, clock stretching, arbitration, packet error codes and bus timeouts belong to the engine or to other logic.

Top module: `smbus_seq`

## Requirements
- R1: Kind 0 (quick) issues a single start (op 1 when rd_bit_i is set, op 0 otherwise) with address byte {addr_i, rd_bit_i}, then a stop (op 5). It sends no data byte and ends without error when the address is acknowledged.
- R2: Kind 1 (send byte) sends wdata_i[7:0] after a write start. Kind 2 (receive byte) starts with a read start, receives one byte with op 4 (receive, not acknowledged), returns it on rdata_o[7:0] with the upper byte zero, and stops.
- R3: Kinds 3 (write byte) and 5 (write word) issue a write start, send cmd_byte_i, then send wdata_i[7:0] and, for a word, wdata_i[15:8] next, then stop.
- R4: Kinds 4 (read byte) and 6 (read word) issue a write start and send cmd_byte_i. They then issue a read start with address byte {addr_i,1} and receive 1 or 2 bytes, every byte but the final one with op 3 and the final one with op 4, then stop. The first received byte lands on rdata_o[7:0] and the second on rdata_o[15:8].
- R5: If the first start is not acknowledged, the transaction ends at once with error set and no stop is issued.
- R6: If the read start that follows a command byte is not acknowledged, a stop is issued and the transaction then ends with error set.
- R7: Kind 7 (block write) clamps len_i to 32. After cmd_byte_i it sends the clamped length as a count byte only when cnt_en_i is set, then sends the stored bytes at index 0 upward, then stops. A byte that is not acknowledged does not stop the transfer and does not set error.
- R8: Kind 8 (block read) with skip_cmd_i set begins directly with a read start, and with it clear uses the write start, command byte and read start order of R4. With cnt_en_i clear it receives the clamped len_i bytes into the store at index 0 upward, the last with op 4.
- R9: In a block read with cnt_en_i set, the first received byte is a count taken with op 3. If that count is zero or larger than the clamped len_i, no data byte is received, the stop follows at once, rlen_o is 0 and the store is untouched. Otherwise that many bytes are received.
- R10: Opcodes are 0 write start, 1 read start, 2 send, 3 receive with acknowledge, 4 receive without acknowledge, 5 stop. A request and its byte stay unchanged until eng_rdy_i accepts it, and only the listed primitives are requested.
- R11: busy_o rises the cycle after an accepted start and falls with done. While busy, start pulses and host writes to the store are ignored.
- R12: done_o is high for exactly one cycle. err_o is cleared when a start is accepted and holds its value until the next accepted start. rlen_o gives the number of data bytes received, not counting a count byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| kind_i | input | 4 | Transaction kind, 0 to 8 |
| addr_i | input | 7 | Target address |
| cmd_byte_i | input | 8 | Command byte |
| wdata_i | input | 16 | Immediate write data, low byte sent first |
| len_i | input | 8 | Requested block length / read capacity |
| rd_bit_i | input | 1 | Direction bit for a quick transaction |
| cnt_en_i | input | 1 | Block count byte is sent or received |
| skip_cmd_i | input | 1 | Block read without command phase |
| buf_we_i | input | 1 | Host write to the byte store |
| buf_idx_i | input | 5 | Host store index |
| buf_wdata_i | input | 8 | Host store write byte |
| buf_rdata_o | output | 8 | Store byte at buf_idx_i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last transaction failed |
| rdata_o | output | 16 | Byte or word read result |
| rlen_o | output | 6 | Data bytes received |
| eng_req_o | output | 1 | Primitive request valid |
| eng_op_o | output | 3 | Primitive opcode |
| eng_data_o | output | 8 | Address byte or byte to send |
| eng_rdy_i | input | 1 | Engine accepts and completes the primitive |
| eng_ack_i | input | 1 | Acknowledge seen, valid with eng_rdy_i |
| eng_rdata_i | input | 8 | Received byte, valid with eng_rdy_i |

## Verification
busy_o is due one cycle after the edge that accepts start. The next request is due one cycle after each edge that has eng_rdy_i high. done_o, err_o, rdata_o and rlen_o are due one cycle after the edge that accepts the stop, or the failed first start, and done_o is gone one cycle later. The bench drives inputs and samples outputs on the falling edge. Its engine model answers only at a falling edge, after a chosen wait, and at that moment it compares the held request with the next entry of a queue of expected primitives built from the requirements. Results are read at the first falling edge that shows done_o, and again one cycle later to confirm the pulse width and the held error.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [3:0] {
    K_QUICK = 4'd0, K_SEND = 4'd1, K_RECV = 4'd2, K_WR_BYTE = 4'd3, K_RD_BYTE = 4'd4,
    K_WR_WORD = 4'd5, K_RD_WORD = 4'd6, K_BLK_WR = 4'd7, K_BLK_RD = 4'd8
  } kind_e;

  typedef enum logic [2:0] {
    OP_START_W = 3'd0, OP_START_R = 3'd1, OP_SEND = 3'd2,
    OP_RECV_ACK = 3'd3, OP_RECV_NACK = 3'd4, OP_STOP = 3'd5
  } eng_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CODE, S_RS, S_CNT_TX, S_CNT_RX, S_DATA, S_STOP
  } seq_st_e;

  typedef struct packed {
    logic first_rd;
    logic has_code;
    logic has_rs;
    logic is_read;
    logic cnt_tx;
    logic cnt_rx;
    logic use_buf;
  } shape_t;
endpackage

// File: rtl/smb_seq_decode.sv
module smb_seq_decode
  import smb_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic [3:0]    kind_i,
  input  logic [7:0]    len_i,
  input  logic          rd_bit_i,
  input  logic          cnt_en_i,
  input  logic          skip_cmd_i,
  output shape_t        shape_o,
  output logic [LW-1:0] nbytes_o
);
  logic [LW-1:0] blk_len;

  always_comb begin
    blk_len  = (int'(len_i) > int'(DEPTH)) ? LW'(DEPTH) : LW'(len_i);
    shape_o  = '0;
    nbytes_o = '0;
    case (kind_e'(kind_i))
      K_SEND:    nbytes_o = LW'(1);
      K_RECV: begin
        shape_o.first_rd = 1'b1;
        shape_o.is_read  = 1'b1;
        nbytes_o         = LW'(1);
      end
      K_WR_BYTE: begin
        shape_o.has_code = 1'b1;
        nbytes_o         = LW'(1);
      end
      K_WR_WORD: begin
        shape_o.has_code = 1'b1;
        nbytes_o         = LW'(2);
      end
      K_RD_BYTE, K_RD_WORD: begin
        shape_o.has_code = 1'b1;
        shape_o.has_rs   = 1'b1;
        shape_o.is_read  = 1'b1;
        nbytes_o         = (kind_e'(kind_i) == K_RD_WORD) ? LW'(2) : LW'(1);
      end
      K_BLK_WR: begin
        shape_o.has_code = 1'b1;
        shape_o.cnt_tx   = cnt_en_i;
        shape_o.use_buf  = 1'b1;
        nbytes_o         = blk_len;
      end
      K_BLK_RD: begin
        shape_o.first_rd = skip_cmd_i;
        shape_o.has_code = !skip_cmd_i;
        shape_o.has_rs   = !skip_cmd_i;
        shape_o.is_read  = 1'b1;
        shape_o.cnt_rx   = cnt_en_i;
        shape_o.use_buf  = 1'b1;
        nbytes_o         = blk_len;
      end
      default:   shape_o.first_rd = rd_bit_i;  // quick: address only
    endcase
  end
endmodule

// File: rtl/smb_seq_buf.sv
module smb_seq_buf #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          h_we_i,
  input  logic [IW-1:0] h_idx_i,
  input  logic [7:0]    h_wdata_i,
  output logic [7:0]    h_rdata_o,
  input  logic          s_we_i,
  input  logic [IW-1:0] s_idx_i,
  input  logic [7:0]    s_wdata_i,
  output logic [7:0]    s_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (s_we_i) begin
      mem_q[s_idx_i] <= s_wdata_i;
    end else if (h_we_i && !busy_i) begin
      mem_q[h_idx_i] <= h_wdata_i;
    end
  end

  assign h_rdata_o = mem_q[h_idx_i];
  assign s_rdata_o = mem_q[s_idx_i];

  // R11: host writes are locked out during a transaction
  p_host_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && h_we_i && !(s_we_i && s_idx_i == h_idx_i)
    |=> mem_q[$past(h_idx_i)] == $past(mem_q[h_idx_i]));
endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [6:0]    addr_i,
  input  logic [7:0]    cmd_byte_i,
  input  logic [15:0]   wdata_i,
  input  shape_t        shape_i,
  input  logic [LW-1:0] nbytes_i,
  input  logic [7:0]    buf_rdata_i,
  output logic          buf_we_o,
  output logic [IW-1:0] buf_idx_o,
  output logic [7:0]    buf_wdata_o,
  output logic          eng_req_o,
  output logic [2:0]    eng_op_o,
  output logic [7:0]    eng_data_o,
  input  logic          eng_rdy_i,
  input  logic          eng_ack_i,
  input  logic [7:0]    eng_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [15:0]   rdata_o,
  output logic [LW-1:0] rlen_o
);
  seq_st_e       st_q, body_st;
  shape_t        shp_q;
  logic [6:0]    addr_q;
  logic [7:0]    code_q;
  logic [15:0]   wd_q, rd_q;
  logic [LW-1:0] n_q, cap_q, idx_q, rlen_q;
  logic          err_q, done_q, acc, last;
  eng_op_e       op;

  assign acc       = eng_req_o && eng_rdy_i;
  assign last      = (idx_q == n_q - LW'(1));
  assign busy_o    = (st_q != S_IDLE);
  assign eng_req_o = busy_o;
  assign eng_op_o  = op;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rdata_o   = rd_q;
  assign rlen_o    = rlen_q;

  assign buf_idx_o   = idx_q[IW-1:0];
  assign buf_wdata_o = eng_rdata_i;
  assign buf_we_o    = acc && (st_q == S_DATA) && shp_q.is_read && shp_q.use_buf;

  // phase after address / command / repeated start
  always_comb begin
    if (shp_q.is_read) body_st = shp_q.cnt_rx ? S_CNT_RX : ((n_q == '0) ? S_STOP : S_DATA);
    else               body_st = shp_q.cnt_tx ? S_CNT_TX : ((n_q == '0) ? S_STOP : S_DATA);
  end

  always_comb begin
    op         = OP_STOP;
    eng_data_o = '0;
    case (st_q)
      S_ADDR: begin
        op         = shp_q.first_rd ? OP_START_R : OP_START_W;
        eng_data_o = {addr_q, shp_q.first_rd};
      end
      S_CODE: begin
        op         = OP_SEND;
        eng_data_o = code_q;
      end
      S_RS: begin
        op         = OP_START_R;
        eng_data_o = {addr_q, 1'b1};
      end
      S_CNT_TX: begin
        op         = OP_SEND;
        eng_data_o = 8'(n_q);
      end
      S_CNT_RX: op = OP_RECV_ACK;
      S_DATA: begin
        if (shp_q.is_read) begin
          op = last ? OP_RECV_NACK : OP_RECV_ACK;
        end else begin
          op         = OP_SEND;
          eng_data_o = shp_q.use_buf ? buf_rdata_i : (idx_q[0] ? wd_q[15:8] : wd_q[7:0]);
        end
      end
      default: op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      shp_q  <= '0;
      addr_q <= '0;
      code_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      n_q    <= '0;
      cap_q  <= '0;
      idx_q  <= '0;
      rlen_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          shp_q  <= shape_i;
          addr_q <= addr_i;
          code_q <= cmd_byte_i;
          wd_q   <= wdata_i;
          n_q    <= nbytes_i;
          cap_q  <= nbytes_i;
          idx_q  <= '0;
          rlen_q <= '0;
          rd_q   <= '0;
          err_q  <= 1'b0;
          st_q   <= S_ADDR;
        end
        S_ADDR: if (acc) begin
          if (!eng_ack_i) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= shp_q.has_code ? S_CODE : body_st;
          end
        end
        S_CODE: if (acc) st_q <= shp_q.has_rs ? S_RS : body_st;
        S_RS: if (acc) begin
          if (!eng_ack_i) begin
            err_q <= 1'b1;
            st_q  <= S_STOP;
          end else begin
            st_q <= body_st;
          end
        end
        S_CNT_TX: if (acc) st_q <= (n_q == '0) ? S_STOP : S_DATA;
        S_CNT_RX: if (acc) begin
          if (eng_rdata_i == '0 || int'(eng_rdata_i) > int'(cap_q)) begin
            n_q  <= '0;
            st_q <= S_STOP;
          end else begin
            n_q  <= LW'(eng_rdata_i);
            st_q <= S_DATA;
          end
        end
        S_DATA: if (acc) begin
          if (shp_q.is_read) begin
            rlen_q <= rlen_q + LW'(1);
            if (!shp_q.use_buf) begin
              if (idx_q[0]) rd_q[15:8] <= eng_rdata_i;
              else          rd_q[7:0]  <= eng_rdata_i;
            end
          end
          idx_q <= idx_q + LW'(1);
          if (last) st_q <= S_STOP;
        end
        S_STOP: if (acc) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R10: request held until accepted
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_rdy_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_data_o));
  // R12: single-cycle completion
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12: error flag stable while idle without start
  p_err_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(err_o));
  // R11: start while busy does not reload the transaction
  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(addr_q) && $stable(shp_q));
  // R5: failed first start ends without stop
  p_addr_nack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_ADDR && acc && !eng_ack_i |=> done_o && err_o && !eng_req_o);
  // R6: failed repeated start is followed by a stop
  p_rs_nack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_RS && acc && !eng_ack_i |=> eng_req_o && eng_op_o == OP_STOP);
  // R9: data phase never exceeds the capacity
  p_cnt_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_DATA |-> n_q <= cap_q && n_q != '0);
endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smb_seq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    kind_i,
  input  logic [6:0]    addr_i,
  input  logic [7:0]    cmd_byte_i,
  input  logic [15:0]   wdata_i,
  input  logic [7:0]    len_i,
  input  logic          rd_bit_i,
  input  logic          cnt_en_i,
  input  logic          skip_cmd_i,
  input  logic          buf_we_i,
  input  logic [IW-1:0] buf_idx_i,
  input  logic [7:0]    buf_wdata_i,
  output logic [7:0]    buf_rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [15:0]   rdata_o,
  output logic [LW-1:0] rlen_o,
  output logic          eng_req_o,
  output logic [2:0]    eng_op_o,
  output logic [7:0]    eng_data_o,
  input  logic          eng_rdy_i,
  input  logic          eng_ack_i,
  input  logic [7:0]    eng_rdata_i
);
  shape_t        shape;
  logic [LW-1:0] nbytes;
  logic          s_we;
  logic [IW-1:0] s_idx;
  logic [7:0]    s_wdata, s_rdata;

  smb_seq_decode #(.DEPTH(DEPTH)) u_dec (
    .kind_i    (kind_i),
    .len_i     (len_i),
    .rd_bit_i  (rd_bit_i),
    .cnt_en_i  (cnt_en_i),
    .skip_cmd_i(skip_cmd_i),
    .shape_o   (shape),
    .nbytes_o  (nbytes)
  );

  smb_seq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_o),
    .h_we_i   (buf_we_i),
    .h_idx_i  (buf_idx_i),
    .h_wdata_i(buf_wdata_i),
    .h_rdata_o(buf_rdata_o),
    .s_we_i   (s_we),
    .s_idx_i  (s_idx),
    .s_wdata_i(s_wdata),
    .s_rdata_o(s_rdata)
  );

  smb_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .cmd_byte_i (cmd_byte_i),
    .wdata_i    (wdata_i),
    .shape_i    (shape),
    .nbytes_i   (nbytes),
    .buf_rdata_i(s_rdata),
    .buf_we_o   (s_we),
    .buf_idx_o  (s_idx),
    .buf_wdata_o(s_wdata),
    .eng_req_o  (eng_req_o),
    .eng_op_o   (eng_op_o),
    .eng_data_o (eng_data_o),
    .eng_rdy_i  (eng_rdy_i),
    .eng_ack_i  (eng_ack_i),
    .eng_rdata_i(eng_rdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o),
    .rlen_o     (rlen_o)
  );
endmodule

// File: tb/smbus_seq_test.sv
module smbus_seq_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, rd_bit_i = 1'b0, cnt_en_i = 1'b0, skip_cmd_i = 1'b0;
  logic [3:0]  kind_i = '0;
  logic [6:0]  addr_i = '0;
  logic [7:0]  cmd_byte_i = '0, len_i = '0, buf_wdata_i = '0, eng_rdata_i = '0;
  logic [15:0] wdata_i = '0;
  logic        buf_we_i = 1'b0, eng_rdy_i = 1'b0, eng_ack_i = 1'b0;
  logic [4:0]  buf_idx_i = '0;
  logic [7:0]  buf_rdata_o, eng_data_o;
  logic        busy_o, done_o, err_o, eng_req_o;
  logic [15:0] rdata_o;
  logic [5:0]  rlen_o;
  logic [2:0]  eng_op_o;

  smbus_seq uut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct packed { logic [2:0] op; logic [7:0] data; logic ack; logic [7:0] rx; } ent_t;
  ent_t  q[$];
  string tq[$];
  ent_t  e;
  string et;
  int n_chk = 0, n_fail = 0, lat = 0, wcnt = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(int op, int data, bit ack, int rx, string tag);
    q.push_back('{op: 3'(op), data: 8'(data), ack: ack, rx: 8'(rx)});
    tq.push_back(tag);
  endfunction
  function automatic void p_st(bit rd, int a, bit ack, string tag);
    push(rd ? 1 : 0, (a << 1) | int'(rd), ack, 0, tag);
  endfunction
  function automatic void p_sd(int d, bit ack, string tag); push(2, d, ack, 0, tag); endfunction
  function automatic void p_rv(bit lst, int rx, string tag); push(lst ? 4 : 3, 0, 1'b1, rx, tag); endfunction
  function automatic void p_sp(string tag); push(5, 0, 1'b1, 0, tag); endfunction

  // engine model: answers at falling edge after lat waiting cycles
  always @(negedge clk_i) begin
    if (eng_rdy_i) eng_rdy_i = 1'b0;
    else if (rst_ni && eng_req_o) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected primitive", int'(eng_op_o), 7);
          eng_ack_i = 1'b1; eng_rdata_i = '0;
        end else begin
          e  = q.pop_front();
          et = tq.pop_front();
          chk(eng_op_o == e.op, et, "opcode", int'(eng_op_o), int'(e.op));
          if (e.op <= 3'd2) chk(eng_data_o == e.data, et, "byte", int'(eng_data_o), int'(e.data));
          eng_ack_i = e.ack; eng_rdata_i = e.rx;
        end
        eng_rdy_i = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic run(input int kind, input int a, input int code, input int wd, input int len,
                     input bit rdb, input bit cnt, input bit skip, input bit poke, input string tag,
                     input bit x_err, input int x_rd, input int x_len);
    int k;
    @(negedge clk_i);
    kind_i = 4'(kind); addr_i = 7'(a); cmd_byte_i = 8'(code); wdata_i = 16'(wd);
    len_i = 8'(len); rd_bit_i = rdb; cnt_en_i = cnt; skip_cmd_i = skip; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R11", "busy after start", int'(busy_o), 1);
    chk(err_o == 1'b0, "R12", "err cleared by start", int'(err_o), 0);
    if (poke) begin
      buf_we_i = 1'b1; buf_idx_i = 5'd2; buf_wdata_i = 8'hFF; start_i = 1'b1; kind_i = 4'd2;
      @(negedge clk_i);
      buf_we_i = 1'b0; start_i = 1'b0;
    end
    k = 0;
    while (!done_o && k < 5000) begin
      @(negedge clk_i);
      k++;
    end
    chk(done_o == 1'b1, tag, "done", int'(done_o), 1);
    chk(err_o == x_err, tag, "err", int'(err_o), int'(x_err));
    chk(rdata_o == 16'(x_rd), tag, "rdata", int'(rdata_o), x_rd);
    chk(rlen_o == 6'(x_len), tag, "rlen", int'(rlen_o), x_len);
    chk(q.size() == 0, tag, "primitives left", q.size(), 0);
    chk(busy_o == 1'b0, "R11", "busy at done", int'(busy_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R12", "done one cycle", int'(done_o), 0);
    chk(err_o == x_err, "R12", "err holds", int'(err_o), int'(x_err));
  endtask

  task automatic bwr(input int i, input int v);
    @(negedge clk_i);
    buf_we_i = 1'b1; buf_idx_i = 5'(i); buf_wdata_i = 8'(v);
    @(negedge clk_i);
    buf_we_i = 1'b0;
  endtask

  task automatic bchk(input int i, input int v, input string tag);
    @(negedge clk_i);
    buf_idx_i = 5'(i);
    #1 chk(buf_rdata_o == 8'(v), tag, "store byte", int'(buf_rdata_o), v);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && !eng_req_o, "R11", "reset idle", int'({busy_o, done_o, err_o, eng_req_o}), 0);
    chk(rlen_o == '0 && rdata_o == '0, "R12", "reset results", int'(rlen_o), 0);

    // R1 quick write and quick read
    p_st(0, 'h50, 1, "R1"); p_sp("R1");
    run(0, 'h50, 0, 0, 0, 0, 0, 0, 0, "R1", 0, 0, 0);
    lat = 2;
    p_st(1, 'h2B, 1, "R1"); p_sp("R1");
    run(0, 'h2B, 0, 0, 0, 1, 0, 0, 0, "R1", 0, 0, 0);
    // R5 first start refused: no stop
    p_st(0, 'h11, 0, "R5");
    run(0, 'h11, 0, 0, 0, 0, 0, 0, 0, "R5", 1, 0, 0);
    // R2 send byte / receive byte
    lat = 0;
    p_st(0, 'h22, 1, "R2"); p_sd('hA5, 1, "R2"); p_sp("R2");
    run(1, 'h22, 0, 'h33A5, 0, 0, 0, 0, 0, "R2", 0, 0, 0);
    p_st(1, 'h22, 1, "R2"); p_rv(1, 'h3C, "R2"); p_sp("R2");
    run(2, 'h22, 0, 0, 0, 0, 0, 0, 0, "R2", 0, 'h003C, 1);
    // R3 write byte and word, low byte first
    p_st(0, 'h30, 1, "R3"); p_sd('h12, 1, "R3"); p_sd('h77, 1, "R3"); p_sp("R3");
    run(3, 'h30, 'h12, 'h9977, 0, 0, 0, 0, 0, "R3", 0, 0, 0);
    lat = 1;
    p_st(0, 'h30, 1, "R3"); p_sd('h13, 1, "R3"); p_sd('hEF, 1, "R3"); p_sd('hBE, 1, "R3"); p_sp("R3");
    run(5, 'h30, 'h13, 'hBEEF, 0, 0, 0, 0, 0, "R3", 0, 0, 0);
    // R4 read byte and word through repeated start
    p_st(0, 'h44, 1, "R4"); p_sd('h01, 1, "R4"); p_st(1, 'h44, 1, "R4"); p_rv(1, 'h5A, "R4"); p_sp("R4");
    run(4, 'h44, 'h01, 0, 0, 0, 0, 0, 0, "R4", 0, 'h005A, 1);
    p_st(0, 'h44, 1, "R4"); p_sd('h02, 1, "R4"); p_st(1, 'h44, 1, "R4");
    p_rv(0, 'h34, "R4"); p_rv(1, 'h12, "R4"); p_sp("R4");
    run(6, 'h44, 'h02, 0, 0, 0, 0, 0, 0, "R4", 0, 'h1234, 2);
    // R6 repeated start refused: stop then error
    p_st(0, 'h44, 1, "R6"); p_sd('h03, 1, "R6"); p_st(1, 'h44, 0, "R6"); p_sp("R6");
    run(6, 'h44, 'h03, 0, 0, 0, 0, 0, 0, "R6", 1, 0, 0);

    // R7 block write: clamp to 32 with count byte
    lat = 0;
    for (int i = 0; i < 32; i++) bwr(i, (i * 7 + 3) & 255);
    p_st(0, 'h60, 1, "R7"); p_sd('hC0, 1, "R7"); p_sd(32, 1, "R7");
    for (int i = 0; i < 32; i++) p_sd((i * 7 + 3) & 255, 1, "R7");
    p_sp("R7");
    run(7, 'h60, 'hC0, 0, 40, 0, 1, 0, 0, "R7", 0, 0, 0);
    // R7 and R11: no count, data NACK ignored, store write and start ignored while busy
    lat = 2;
    p_st(0, 'h60, 1, "R7"); p_sd('hC1, 1, "R7"); p_sd(3, 1, "R7"); p_sd(10, 0, "R7");
    p_sd(17, 1, "R11"); p_sp("R7");
    run(7, 'h60, 'hC1, 0, 3, 0, 0, 0, 1, "R7", 0, 0, 0);
    bchk(2, 17, "R11");
    // R7 zero length with count byte
    lat = 0;
    p_st(0, 'h61, 1, "R7"); p_sd('hC2, 1, "R7"); p_sd(0, 1, "R7"); p_sp("R7");
    run(7, 'h61, 'hC2, 0, 0, 0, 1, 0, 0, "R7", 0, 0, 0);

    // R8 block read, no command phase, fixed length
    p_st(1, 'h70, 1, "R8");
    for (int i = 0; i < 4; i++) p_rv(i == 3, 'h11 * (i + 1), "R8");
    p_sp("R8");
    run(8, 'h70, 'hD0, 0, 4, 0, 0, 1, 0, "R8", 0, 0, 4);
    for (int i = 0; i < 4; i++) bchk(i, 'h11 * (i + 1), "R8");
    // R9 block read with count within capacity
    lat = 1;
    p_st(0, 'h71, 1, "R9"); p_sd('hD1, 1, "R9"); p_st(1, 'h71, 1, "R9"); p_rv(0, 3, "R9");
    p_rv(0, 'hA1, "R9"); p_rv(0, 'hA2, "R9"); p_rv(1, 'hA3, "R9"); p_sp("R9");
    run(8, 'h71, 'hD1, 0, 8, 0, 1, 0, 0, "R9", 0, 0, 3);
    bchk(2, 'hA3, "R9");
    // R9 count above capacity: discarded
    p_st(0, 'h71, 1, "R9"); p_sd('hD2, 1, "R9"); p_st(1, 'h71, 1, "R9"); p_rv(0, 9, "R9"); p_sp("R9");
    run(8, 'h71, 'hD2, 0, 8, 0, 1, 0, 0, "R9", 0, 0, 0);
    bchk(0, 'hA1, "R9");
    // R8 fixed length clamped to 32
    lat = 0;
    p_st(1, 'h72, 1, "R8");
    for (int i = 0; i < 32; i++) p_rv(i == 31, i + 100, "R8");
    p_sp("R8");
    run(8, 'h72, 0, 0, 50, 0, 0, 1, 0, "R8", 0, 0, 32);
    bchk(31, 131, "R8");

    summary();
    $finish;
  end
endmodule